// File: doc/BRIEF.md
# Flash Command Decoder with Status

This block sits on the device side of a small NOR-style memory model. A host writes command bytes over a parallel bus, one byte per write strobe. The block decodes them and chooses what a read returns: array contents, identification codes, the status byte or a fixed query signature. It runs a simplified write engine for word program, block erase, erase suspend and resume, and lock-bit set and clear. The engine reports progress in an 8-bit status byte.

The array is a small register file split into equal blocks. Operation time is modelled by down-counters whose lengths are parameters. A ready/busy pin follows the engine either as a level or as short low pulses when an operation finishes. A two-byte command controls the choice. Commands that need two bytes check their second byte. A wrong second byte sets error flags instead of starting anything. While an erase is suspended, only a small set of commands is honoured.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, every location reads 0xFF, no block is locked, the pin reads high in level mode, and the status byte is 0x80. Status bit 7 is ready, bit 6 is erase suspended, bit 5 is erase or clear-lock error, bit 4 is program or set-lock error, bit 3 is locked-block abort, and bits 2:0 read 0.
- R2: Byte 0xFF selects array read, 0x70 status read, 0x90 identifier read and 0x98 query read. In identifier mode, word offset 0 gives the maker code, offset 1 the device code, and offset 2 the lock bit of the addressed block in bit 0. In query mode, offsets 0, 1 and 2 give 0x51, 0x52 and 0x59. An unrecognised byte changes nothing.
- R3: Byte 0x40 followed by a data write starts a program at the address of the data write. Status bit 7 reads 0 for exactly PROG_CYC cycles. The location then holds its old value AND the data, and the read mode is status.
- R4: Byte 0x20 followed by 0xD0 at an address starts an erase of that address's block. Bit 7 reads 0 for exactly ERASE_CYC cycles. The whole block then reads 0xFF, and other blocks are unchanged.
- R5: If the byte after 0x20 is not 0xD0, status bits 5 and 4 are set and nothing is erased.
- R6: Byte 0x60 followed by 0x01 sets the lock bit of the addressed block, and 0x60 followed by 0xD0 clears all lock bits. Each is busy for LOCK_CYC cycles. Any other second byte sets bits 5 and 4.
- R7: A program into a locked block sets bits 4 and 3, and an erase of a locked block sets bits 5 and 3. In both cases the engine is never busy and the array is unchanged.
- R8: Byte 0xB0 during an erase suspends it. Bits 7 and 6 read 1, and the erase makes no progress however long it waits. Byte 0xD0 resumes it, and it then finishes within ERASE_CYC cycles.
- R9: While an erase is suspended, only 0xFF, 0x70, 0x98, 0x50, 0xB8 and 0xD0 are accepted. Program (0x40) and identifier (0x90) writes are ignored.
- R10: Byte 0x50 clears status bits 5, 4 and 3 and leaves the read mode unchanged.
- R11: With pin code 00 (level mode), the pin is low exactly while the engine is busy and not suspended.
- R12: Byte 0xB8 followed by a code byte sets the pin mode from the code's bits 1:0. Bit 1 selects a low pulse of PULSE_LEN cycles when a program completes, and bit 0 selects the same pulse when an erase completes. In either pulse mode the pin stays high while busy.
- R13: While the engine is busy and not suspended, every write other than an erase suspend is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one byte per cycle |
| wrAddr | input | ADDR_W | Write address (block and word offset) |
| wrData | input | 8 | Command or data byte |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read data for the current read mode |
| sts | output | 1 | Ready/busy or completion-pulse pin |

## Verification
A table of command and read vectors moves through every read mode. It shows that the mode byte, not the address, chooses between array data, identification codes, status and query signature. An unknown byte is shown to leave the mode alone. Directed sequences then pair each two-byte command with its correct and incorrect second bytes, and with locked and unlocked blocks. The resulting status bytes tell a sequence error apart from a lock abort. Busy-cycle counts separate program, erase and lock timing. Pin-pulse counts in each pin mode tell a program completion from an erase completion. A suspended erase is hit with accepted and rejected commands, and the array is read before and after resume.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY,
    RM_IDENT,
    RM_STATUS,
    RM_QUERY
  } readMode_t;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_PROG_DATA,
    CS_ERASE_CONF,
    CS_LOCK_CONF,
    CS_CFG_CODE
  } cmdState_t;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_ERASE,
    OP_LOCK_SET,
    OP_LOCK_CLR
  } opKind_t;

  // strobes from the control to the storage, valid in the completion cycle
  typedef struct packed {
    logic progWr;
    logic eraseBlk;
    logic lockSet;
    logic lockClr;
  } arrayStrb_t;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_READ_IDENT  = 8'h90;
  localparam logic [7:0] CMD_READ_QUERY  = 8'h98;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_PROGRAM     = 8'h40;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_LOCK        = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET    = 8'h01;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_PIN_CFG     = 8'hB8;

endpackage

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20,
  parameter int LOCK_CYC  = 4,
  parameter int PULSE_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              wrBlkLocked,
  output readMode_t         rdMode,
  output logic [7:0]        status,
  output arrayStrb_t        strb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic              sts,
  output logic [1:0]        stsCfg
);

  localparam int MAX_AB  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_CYC = (MAX_AB > LOCK_CYC) ? MAX_AB : LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int PUL_W   = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LD  = CNT_W'(LOCK_CYC - 1);
  localparam logic [PUL_W-1:0] PULSE_LD = PUL_W'(PULSE_LEN);

  cmdState_t         state;
  opKind_t           op;
  logic              busy, susp;
  logic              errErase, errProg, errLock;
  logic [CNT_W-1:0]  cnt;
  logic [PUL_W-1:0]  pulseCnt;
  logic              active, doneNow;

  assign active  = busy & ~susp;
  assign doneNow = active & (cnt == '0);

  always_comb begin
    strb          = '0;
    strb.progWr   = doneNow && (op == OP_PROG);
    strb.eraseBlk = doneNow && (op == OP_ERASE);
    strb.lockSet  = doneNow && (op == OP_LOCK_SET);
    strb.lockClr  = doneNow && (op == OP_LOCK_CLR);
  end

  assign status = {~active, susp, errErase, errProg, errLock, 3'b000};
  assign sts    = (stsCfg == 2'b00) ? ~active : (pulseCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= CS_IDLE;
      op       <= OP_PROG;
      rdMode   <= RM_ARRAY;
      busy     <= 1'b0;
      susp     <= 1'b0;
      errErase <= 1'b0;
      errProg  <= 1'b0;
      errLock  <= 1'b0;
      cnt      <= '0;
      pulseCnt <= '0;
      stsCfg   <= 2'b00;
      opAddr   <= '0;
      opData   <= '0;
    end else begin
      if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;

      if (active) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if ((op == OP_PROG && stsCfg[1]) || (op == OP_ERASE && stsCfg[0]))
            pulseCnt <= PULSE_LD;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end

      if (wrEn) begin
        if (active) begin
          // only an erase suspend gets through while the engine runs
          if (wrData == CMD_SUSPEND && op == OP_ERASE && cnt != '0) begin
            susp   <= 1'b1;
            rdMode <= RM_STATUS;
          end
        end else if (state != CS_IDLE) begin
          state <= CS_IDLE;
          case (state)
            CS_PROG_DATA: begin
              if (wrBlkLocked) begin
                errProg <= 1'b1;
                errLock <= 1'b1;
              end else begin
                busy   <= 1'b1;
                op     <= OP_PROG;
                cnt    <= PROG_LD;
                opAddr <= wrAddr;
                opData <= wrData;
              end
            end
            CS_ERASE_CONF: begin
              if (wrData != CMD_CONFIRM) begin
                errErase <= 1'b1;
                errProg  <= 1'b1;
              end else if (wrBlkLocked) begin
                errErase <= 1'b1;
                errLock  <= 1'b1;
              end else begin
                busy   <= 1'b1;
                op     <= OP_ERASE;
                cnt    <= ERASE_LD;
                opAddr <= wrAddr;
              end
            end
            CS_LOCK_CONF: begin
              if (wrData == CMD_LOCK_SET || wrData == CMD_CONFIRM) begin
                busy   <= 1'b1;
                op     <= (wrData == CMD_LOCK_SET) ? OP_LOCK_SET : OP_LOCK_CLR;
                cnt    <= LOCK_LD;
                opAddr <= wrAddr;
              end else begin
                errErase <= 1'b1;
                errProg  <= 1'b1;
              end
            end
            CS_CFG_CODE: stsCfg <= wrData[1:0];
            default: ;
          endcase
        end else if (susp) begin
          case (wrData)
            CMD_READ_ARRAY:  rdMode <= RM_ARRAY;
            CMD_READ_STATUS: rdMode <= RM_STATUS;
            CMD_READ_QUERY:  rdMode <= RM_QUERY;
            CMD_CLR_STATUS: begin
              errErase <= 1'b0;
              errProg  <= 1'b0;
              errLock  <= 1'b0;
            end
            CMD_PIN_CFG: state <= CS_CFG_CODE;
            CMD_CONFIRM: begin
              susp   <= 1'b0;
              rdMode <= RM_STATUS;
            end
            default: ;
          endcase
        end else begin
          case (wrData)
            CMD_READ_ARRAY:  rdMode <= RM_ARRAY;
            CMD_READ_STATUS: rdMode <= RM_STATUS;
            CMD_READ_IDENT:  rdMode <= RM_IDENT;
            CMD_READ_QUERY:  rdMode <= RM_QUERY;
            CMD_CLR_STATUS: begin
              errErase <= 1'b0;
              errProg  <= 1'b0;
              errLock  <= 1'b0;
            end
            CMD_PROGRAM: begin
              state  <= CS_PROG_DATA;
              rdMode <= RM_STATUS;
            end
            CMD_ERASE: begin
              state  <= CS_ERASE_CONF;
              rdMode <= RM_STATUS;
            end
            CMD_LOCK: begin
              state  <= CS_LOCK_CONF;
              rdMode <= RM_STATUS;
            end
            CMD_PIN_CFG: state <= CS_CFG_CODE;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int         NUM_BLOCKS  = 4,
  parameter int         BLOCK_WORDS = 8,
  parameter logic [7:0] MFR_CODE    = 8'h89,
  parameter logic [7:0] DEV_CODE    = 8'h17,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int OFS_W  = $clog2(BLOCK_WORDS),
  localparam int ADDR_W = BLK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  arrayStrb_t        strb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        opData,
  input  logic [BLK_W-1:0]  wrBlk,
  output logic              wrBlkLocked,
  input  readMode_t         rdMode,
  input  logic [7:0]        status,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  logic [BLK_W-1:0]                opBlk, rdBlk;
  logic [OFS_W-1:0]                opOfs, rdOfs;
  logic [NUM_BLOCKS-1:0]           lockVec;
  logic [NUM_BLOCKS-1:0][7:0]      rdWordVec;

  assign opBlk = opAddr[ADDR_W-1:OFS_W];
  assign opOfs = opAddr[OFS_W-1:0];
  assign rdBlk = rdAddr[ADDR_W-1:OFS_W];
  assign rdOfs = rdAddr[OFS_W-1:0];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [7:0] words [BLOCK_WORDS];
    logic       locked;
    logic       hit;

    assign hit = (opBlk == BLK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < BLOCK_WORDS; w++) words[w] <= 8'hFF;
        locked <= 1'b0;
      end else begin
        if (strb.eraseBlk && hit) begin
          for (int w = 0; w < BLOCK_WORDS; w++) words[w] <= 8'hFF;
        end else if (strb.progWr && hit) begin
          words[opOfs] <= words[opOfs] & opData;
        end
        if (strb.lockSet && hit)  locked <= 1'b1;
        else if (strb.lockClr)    locked <= 1'b0;
      end
    end

    assign lockVec[b]   = locked;
    assign rdWordVec[b] = words[rdOfs];
  end

  assign wrBlkLocked = lockVec[wrBlk];

  always_comb begin
    rdData = 8'h00;
    case (rdMode)
      RM_ARRAY:  rdData = rdWordVec[rdBlk];
      RM_STATUS: rdData = status;
      RM_IDENT: begin
        if (rdOfs == OFS_W'(0))      rdData = MFR_CODE;
        else if (rdOfs == OFS_W'(1)) rdData = DEV_CODE;
        else if (rdOfs == OFS_W'(2)) rdData = {7'b0, lockVec[rdBlk]};
      end
      RM_QUERY: begin
        if (rdOfs == OFS_W'(0))      rdData = 8'h51;
        else if (rdOfs == OFS_W'(1)) rdData = 8'h52;
        else if (rdOfs == OFS_W'(2)) rdData = 8'h59;
      end
      default: rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         NUM_BLOCKS  = 4,
  parameter int         BLOCK_WORDS = 8,
  parameter int         PROG_CYC    = 6,
  parameter int         ERASE_CYC   = 20,
  parameter int         LOCK_CYC    = 4,
  parameter int         PULSE_LEN   = 3,
  parameter logic [7:0] MFR_CODE    = 8'h89,
  parameter logic [7:0] DEV_CODE    = 8'h17,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int OFS_W  = $clog2(BLOCK_WORDS),
  localparam int ADDR_W = BLK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              sts
);

  readMode_t         rdMode;
  logic [7:0]        status;
  arrayStrb_t        strb;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic              wrBlkLocked;
  logic [1:0]        stsCfg;
  logic              opDone;

  assign opDone = |strb;

  flash_cmd_ctl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .LOCK_CYC(LOCK_CYC), .PULSE_LEN(PULSE_LEN)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrBlkLocked(wrBlkLocked), .rdMode(rdMode), .status(status), .strb(strb),
    .opAddr(opAddr), .opData(opData), .sts(sts), .stsCfg(stsCfg)
  );

  flash_cmd_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .opData(opData),
    .wrBlk(wrAddr[ADDR_W-1:OFS_W]), .wrBlkLocked(wrBlkLocked),
    .rdMode(rdMode), .status(status), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       statReady,
  input logic       statSusp,
  input logic       statProgErr,
  input logic       sts,
  input logic [1:0] stsCfg,
  input logic       opDone
);

  // R3
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> statReady);

  // R13
  busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statReady) |-> $past(wrEn));

  // R8
  susp_is_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    statSusp |-> statReady);

  // R9
  susp_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statSusp && !(wrEn && wrData == 8'hD0)) |=> statSusp);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statProgErr) |-> $past(wrEn && wrData == 8'h50));

  // R12
  pulse_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sts) && stsCfg != 2'b00) |-> $past(opDone));

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .statReady(status[7]), .statSusp(status[6]), .statProgErr(status[4]),
  .sts(sts), .stsCfg(stsCfg), .opDone(opDone)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 20;
  localparam int LOCK_CYC  = 4;
  localparam int PULSE_LEN = 3;

  typedef struct packed {
    logic       isRd;
    logic [4:0] addr;
    logic [7:0] data;
  } vec_t;

  // read-mode walk, R1 and R2
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd5,  8'hFF},  // R1 erased array
    '{1'b0, 5'd0,  8'h90},
    '{1'b1, 5'd0,  8'h89},
    '{1'b1, 5'd1,  8'h17},
    '{1'b1, 5'd2,  8'h00},
    '{1'b0, 5'd0,  8'h98},
    '{1'b1, 5'd8,  8'h51},
    '{1'b1, 5'd10, 8'h59},
    '{1'b0, 5'd0,  8'h70},
    '{1'b1, 5'd3,  8'h80},  // R1 status reset value
    '{1'b0, 5'd0,  8'hFF},
    '{1'b0, 5'd0,  8'h12},  // unknown byte
    '{1'b1, 5'd3,  8'hFF}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [4:0] rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       sts;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  flash_cmd_ctrl #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .LOCK_CYC(LOCK_CYC), .PULSE_LEN(PULSE_LEN)
  ) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sts(sts)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  // counts cycles with ready low; call right after a write, mode status
  task automatic busyCycles(output int n);
    n = 0;
    #1;
    while (rdData[7] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pinLows(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!sts) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pin high after reset", {7'b0, sts}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd) begin
        rd(VECS[i].addr, v);
        chk($sformatf("R2 vector %0d", i), v, VECS[i].data);
      end else begin
        wr(VECS[i].addr, VECS[i].data);
      end
    end

    // R3 program, R11 level pin
    wr(5, 8'h40); wr(5, 8'hA5);
    chk("R11 pin low while busy", {7'b0, sts}, 8'h00);
    busyCycles(n);
    chk("R3 program busy cycles", 8'(n), 8'(PROG_CYC));
    chk("R11 pin high when ready", {7'b0, sts}, 8'h01);
    rd(0, v); chk("R3 status after program", v, 8'h80);
    wr(5, 8'h40); wr(5, 8'h0F); busyCycles(n);
    wr(0, 8'hFF); rd(5, v); chk("R3 program ANDs bits", v, 8'h05);

    // R4 erase
    wr(9, 8'h40); wr(9, 8'h00); busyCycles(n);
    wr(2, 8'h20); wr(2, 8'hD0); busyCycles(n);
    chk("R4 erase busy cycles", 8'(n), 8'(ERASE_CYC));
    wr(0, 8'hFF); rd(5, v); chk("R4 block erased", v, 8'hFF);
    rd(9, v); chk("R4 other block kept", v, 8'h00);

    // R5 bad confirm, R10 clear
    wr(8, 8'h20); wr(8, 8'h33);
    rd(0, v); chk("R5 bad erase confirm", v, 8'hB0);
    wr(0, 8'h50); rd(0, v); chk("R10 clear status", v, 8'h80);
    wr(0, 8'hFF); rd(9, v); chk("R5 no erase", v, 8'h00);

    // R6 lock set
    wr(8, 8'h60); wr(8, 8'h01); busyCycles(n);
    chk("R6 lock busy cycles", 8'(n), 8'(LOCK_CYC));
    wr(0, 8'h90); rd(10, v); chk("R6 lock bit set", v, 8'h01);
    rd(2, v); chk("R6 other block unlocked", v, 8'h00);

    // R7 locked aborts
    wr(8, 8'h20); wr(8, 8'hD0);
    rd(0, v); chk("R7 erase locked", v, 8'hA8);
    wr(0, 8'h50); wr(0, 8'hFF); rd(9, v); chk("R7 array kept", v, 8'h00);
    wr(12, 8'h40); wr(12, 8'h00);
    rd(0, v); chk("R7 program locked", v, 8'h98);
    wr(0, 8'h50); wr(0, 8'hFF); rd(12, v); chk("R7 program blocked", v, 8'hFF);

    // R6 bad second byte, clear locks
    wr(0, 8'h60); wr(0, 8'h77);
    rd(0, v); chk("R6 bad lock byte", v, 8'hB0);
    wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'hD0); busyCycles(n);
    wr(0, 8'h90); rd(10, v); chk("R6 locks cleared", v, 8'h00);

    // R12 pin pulse modes
    wr(0, 8'hB8); wr(0, 8'h02);
    wr(16, 8'h40); wr(16, 8'h3C);
    chk("R12 pin high while busy", {7'b0, sts}, 8'h01);
    pinLows(PROG_CYC + PULSE_LEN + 4, n);
    chk("R12 program pulse length", 8'(n), 8'(PULSE_LEN));
    wr(0, 8'hFF); rd(16, v); chk("R3 programmed value", v, 8'h3C);
    wr(16, 8'h20); wr(16, 8'hD0);
    pinLows(ERASE_CYC + PULSE_LEN + 4, n);
    chk("R12 no pulse on erase in code 10", 8'(n), 8'd0);
    wr(0, 8'hB8); wr(0, 8'h03);
    wr(16, 8'h20); wr(16, 8'hD0);
    pinLows(ERASE_CYC + PULSE_LEN + 4, n);
    chk("R12 erase pulse in code 11", 8'(n), 8'(PULSE_LEN));
    wr(0, 8'hB8); wr(0, 8'h00);

    // R8 and R9 suspend
    wr(24, 8'h40); wr(24, 8'h00); busyCycles(n);
    wr(24, 8'h20); wr(24, 8'hD0);
    repeat (5) @(negedge clk);
    wr(0, 8'hB0);
    rd(0, v); chk("R8 suspended status", v, 8'hC0);
    repeat (50) @(negedge clk);
    rd(0, v); chk("R8 no progress while suspended", v, 8'hC0);
    chk("R11 pin high while suspended", {7'b0, sts}, 8'h01);
    wr(0, 8'hFF); rd(24, v); chk("R9 array read while suspended", v, 8'h00);
    wr(16, 8'h40); wr(16, 8'h00);
    rd(16, v); chk("R9 program rejected", v, 8'hFF);
    wr(0, 8'h90); rd(25, v); chk("R9 identifier rejected", v, 8'hFF);
    wr(0, 8'h70); rd(0, v); chk("R9 status accepted", v, 8'hC0);
    wr(0, 8'hD0); busyCycles(n);
    chk("R8 resume finishes in time", {7'b0, (n > 0 && n <= ERASE_CYC)}, 8'h01);
    rd(0, v); chk("R8 ready after resume", v, 8'h80);
    wr(0, 8'hFF); rd(24, v); chk("R8 erase completed", v, 8'hFF);

    // R13 writes ignored while busy
    wr(28, 8'h40); wr(28, 8'h5A);
    wr(0, 8'hFF); wr(0, 8'h90);
    busyCycles(n);
    rd(0, v); chk("R13 mode unchanged by busy writes", v, 8'h80);
    wr(0, 8'hFF); rd(28, v); chk("R13 program unaffected", v, 8'h5A);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    rd(28, v); chk("R1 array reset", v, 8'hFF);
    chk("R1 pin after reset", {7'b0, sts}, 8'h01);
    wr(0, 8'h90); rd(10, v); chk("R1 no locks after reset", v, 8'h00);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule